// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits in front of one DRAM channel shared by several banks. It keeps pending memory requests (thread id, bank, row, column) in a request buffer and mirrors the open row of every bank. Each cycle it offers one request on its issue port. A request whose row is already open in its bank outranks every request that would need a new row. Among requests of equal rank, the one that arrived first goes first.

After an issue, the target bank stays busy for a short latency on a row hit or a longer latency on a row conflict. While a bank is busy, its requests are not eligible. A conflict closes the bank's row at once and opens the requested row when the access completes. A separate update port lets the downstream command model force a bank's open row. Request age comes from an arrival stamp that wraps, and stamps are compared modulo their width.

Top module: `dram_rowhit_sched`

## Requirements
- R1: Among requests to banks that are not busy, a request whose row equals the open row of its bank is issued before any request that misses; `iss_hit` is 1 exactly when the offered request is such a hit.
- R2: Among eligible requests with the same hit status, the one enqueued earliest is offered.
- R3: A request issued as a hit keeps its bank busy for HIT_LAT cycles, and one issued as a conflict keeps it busy for MISS_LAT cycles. Counting starts at the issue edge, and the bank is eligible again in the cycle after the last busy cycle. No request to a busy bank is offered.
- R4: A conflict issue marks the bank as having no open row from the issue edge onward. The requested row becomes the open row at the edge where the busy time ends.
- R5: After reset the buffer is empty, every bank is idle with no open row, `iss_valid` is 0 and `enq_ready` is 1.
- R6: The buffer holds DEPTH requests (128 by default). `enq_ready` is 0 when all entries are occupied, and an enqueue offered while `enq_ready` is 0 is dropped.
- R7: `upd_valid` sets the open row of `upd_bank` to `upd_row` at the next edge. If this falls on the edge where a conflict completes in the same bank, the update port's row wins.
- R8: A request leaves the buffer only on an edge where `iss_valid` and `iss_ready` are both 1. It stays pending while `iss_ready` is 0.
- R9: Age ordering stays correct when the STAMP_W-bit arrival stamp wraps around, as long as the pending requests span fewer than 2^(STAMP_W-1) arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Buffer has a free entry |
| enq_tid | input | TID_W | Thread id of the new request |
| enq_bank | input | log2(NBANK) | Bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_col | input | COL_W | Column of the new request |
| iss_valid | output | 1 | A request is offered for issue |
| iss_ready | input | 1 | Command model accepts the offered request |
| iss_tid | output | TID_W | Thread id of the offered request |
| iss_bank | output | log2(NBANK) | Bank of the offered request |
| iss_row | output | ROW_W | Row of the offered request |
| iss_col | output | COL_W | Column of the offered request |
| iss_hit | output | 1 | Offered request hits the open row |
| upd_valid | input | 1 | Force a bank's open row |
| upd_bank | input | log2(NBANK) | Bank to update |
| upd_row | input | ROW_W | Row that becomes open |

## Verification
In one bank, the end of a conflict access and a forced open-row update from the update port can land on the same edge. Both write the bank's open row. The bench provokes this by queuing a conflict to one row and two later requests, an older one to that same row and a newer one to another row. It waits for the conflict to issue and drives the update to the other row exactly MISS_LAT edges later. The outcome is judged by which of the two pending requests is offered next as a hit.

// File: rtl/dram_rowhit_sched.sv
module dram_rowhit_sched #(
  parameter int NBANK    = 4,
  parameter int DEPTH    = 128,
  parameter int TID_W    = 4,
  parameter int ROW_W    = 14,
  parameter int COL_W    = 7,
  parameter int STAMP_W  = 16,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 8,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int LAT_W   = $clog2(MISS_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [TID_W-1:0]  enq_tid,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [COL_W-1:0]  enq_col,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [TID_W-1:0]  iss_tid,
  output logic [BANK_W-1:0] iss_bank,
  output logic [ROW_W-1:0]  iss_row,
  output logic [COL_W-1:0]  iss_col,
  output logic              iss_hit,
  input  logic              upd_valid,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row
);

  logic [DEPTH-1:0]   e_vld;
  logic [TID_W-1:0]   e_tid   [DEPTH];
  logic [BANK_W-1:0]  e_bank  [DEPTH];
  logic [ROW_W-1:0]   e_row   [DEPTH];
  logic [COL_W-1:0]   e_col   [DEPTH];
  logic [STAMP_W-1:0] e_stamp [DEPTH];
  logic [STAMP_W-1:0] stamp_nxt;

  logic [LAT_W-1:0]   b_cnt  [NBANK];
  logic [ROW_W-1:0]   b_row  [NBANK];
  logic [ROW_W-1:0]   b_prow [NBANK];
  logic [NBANK-1:0]   b_open, b_pend;

  logic               found, sel_hit;
  logic [IDX_W-1:0]   sel, free_idx;
  logic [STAMP_W-1:0] sel_st;
  logic               do_enq, do_iss;

  function automatic logic older(input logic [STAMP_W-1:0] a, input logic [STAMP_W-1:0] b);
    logic [STAMP_W-1:0] d;
    d = a - b;
    return d[STAMP_W-1];
  endfunction

  always_comb begin
    logic h, el;
    found   = 1'b0;
    sel     = '0;
    sel_hit = 1'b0;
    sel_st  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      h  = b_open[e_bank[i]] && (b_row[e_bank[i]] == e_row[i]);
      el = e_vld[i] && (b_cnt[e_bank[i]] == '0);
      if (el && (!found || (h && !sel_hit) || (h == sel_hit && older(e_stamp[i], sel_st)))) begin
        found   = 1'b1;
        sel     = IDX_W'(i);
        sel_hit = h;
        sel_st  = e_stamp[i];
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!e_vld[i]) free_idx = IDX_W'(i);
  end

  assign enq_ready = ~&e_vld;
  assign do_enq    = enq_valid && enq_ready;
  assign iss_valid = found;
  assign do_iss    = found && iss_ready;
  assign iss_tid   = e_tid[sel];
  assign iss_bank  = e_bank[sel];
  assign iss_row   = e_row[sel];
  assign iss_col   = e_col[sel];
  assign iss_hit   = sel_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld     <= '0;
      stamp_nxt <= '0;
    end else begin
      if (do_enq) begin
        e_vld[free_idx] <= 1'b1;
        stamp_nxt       <= stamp_nxt + 1'b1;
      end
      if (do_iss) e_vld[sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_enq) begin
      e_tid[free_idx]   <= enq_tid;
      e_bank[free_idx]  <= enq_bank;
      e_row[free_idx]   <= enq_row;
      e_col[free_idx]   <= enq_col;
      e_stamp[free_idx] <= stamp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_open <= '0;
      b_pend <= '0;
      for (int b = 0; b < NBANK; b++) begin
        b_cnt[b]  <= '0;
        b_row[b]  <= '0;
        b_prow[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (b_cnt[b] != '0) begin
          b_cnt[b] <= b_cnt[b] - 1'b1;
          if (b_cnt[b] == LAT_W'(1) && b_pend[b]) begin
            b_open[b] <= 1'b1;
            b_row[b]  <= b_prow[b];
            b_pend[b] <= 1'b0;
          end
        end
        if (do_iss && iss_bank == BANK_W'(b)) begin
          b_cnt[b] <= sel_hit ? LAT_W'(HIT_LAT) : LAT_W'(MISS_LAT);
          if (!sel_hit) begin
            b_open[b] <= 1'b0;
            b_prow[b] <= iss_row;
            b_pend[b] <= 1'b1;
          end
        end
        if (upd_valid && upd_bank == BANK_W'(b)) begin
          b_open[b] <= 1'b1;
          b_row[b]  <= upd_row;
        end
      end
    end
  end

  logic any_free_hit;
  always_comb begin
    any_free_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (e_vld[i] && b_cnt[e_bank[i]] == '0 && b_open[e_bank[i]] && b_row[e_bank[i]] == e_row[i])
        any_free_hit = 1'b1;
  end

  p_hit_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_hit) |-> !any_free_hit);

  p_busy_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !(iss_valid && iss_bank == $past(iss_bank)));

  p_miss_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !iss_hit && !(upd_valid && upd_bank == iss_bank)) |=> !b_open[$past(iss_bank)]);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_ready |-> ($countones(e_vld) == DEPTH));

endmodule

// File: tb/test_dram_rowhit_sched.sv
module test_dram_rowhit_sched;
  localparam int HL = 2;
  localparam int ML = 8;
  localparam int DEP = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, iss_ready = 1'b0, upd_valid = 1'b0;
  logic [3:0] enq_tid = '0;
  logic [1:0] enq_bank = '0, upd_bank = '0;
  logic [13:0] enq_row = '0, upd_row = '0;
  logic [6:0] enq_col = '0;
  logic enq_ready, iss_valid, iss_hit;
  logic [3:0] iss_tid;
  logic [1:0] iss_bank;
  logic [13:0] iss_row;
  logic [6:0] iss_col;

  always #10 clk = ~clk;

  dram_rowhit_sched #(.STAMP_W(9), .HIT_LAT(HL), .MISS_LAT(ML)) i_dram_rowhit_sched (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_tid(enq_tid), .enq_bank(enq_bank),
    .enq_row(enq_row), .enq_col(enq_col),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tid(iss_tid), .iss_bank(iss_bank),
    .iss_row(iss_row), .iss_col(iss_col), .iss_hit(iss_hit),
    .upd_valid(upd_valid), .upd_bank(upd_bank), .upd_row(upd_row));

  typedef struct { int tid; int bank; int row; int col; int seq; } req_t;
  req_t pool[$];
  int m_cnt[4], m_orow[4], m_prow[4];
  bit m_open[4], m_pend[4];
  int seq = 0, issued = 0, checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(int tid, int bank, int row, int col, bit hit);
    return {36'd0, 4'(tid), 2'(bank), 14'(row), 7'(col), hit};
  endfunction

  // monitor: scoreboard pool and bank mirror, compares each cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int best;
      bit bhit, enq_ok;
      cycles++;
      best = -1;
      bhit = 0;
      foreach (pool[k]) begin
        int b;
        bit h;
        b = pool[k].bank;
        if (m_cnt[b] == 0) begin
          h = m_open[b] && m_orow[b] == pool[k].row;
          if (best < 0 || (h && !bhit) || (h == bhit && pool[k].seq < pool[best].seq)) begin
            best = k;
            bhit = h;
          end
        end
      end
      check("R3 R5 R8 iss_valid", 64'(iss_valid), 64'(best >= 0));
      if (best >= 0 && iss_valid)
        check("R1 R2 R3 R4 R7 R9 issue",
              pack(iss_tid, iss_bank, iss_row, iss_col, iss_hit),
              pack(pool[best].tid, pool[best].bank, pool[best].row, pool[best].col, bhit));
      enq_ok = pool.size() < DEP;
      check("R6 enq_ready", 64'(enq_ready), 64'(enq_ok));
      for (int b = 0; b < 4; b++)
        if (m_cnt[b] > 0) begin
          m_cnt[b]--;
          if (m_cnt[b] == 0 && m_pend[b]) begin
            m_open[b] = 1;
            m_orow[b] = m_prow[b];
            m_pend[b] = 0;
          end
        end
      if (best >= 0 && iss_ready) begin
        int b;
        b = pool[best].bank;
        m_cnt[b] = bhit ? HL : ML;
        if (!bhit) begin
          m_open[b] = 0;
          m_prow[b] = pool[best].row;
          m_pend[b] = 1;
        end
        pool.delete(best);
        issued++;
      end
      if (upd_valid) begin
        m_open[upd_bank] = 1;
        m_orow[upd_bank] = upd_row;
      end
      if (enq_valid && enq_ok) begin
        req_t r;
        r.tid = enq_tid; r.bank = enq_bank; r.row = enq_row; r.col = enq_col; r.seq = seq;
        seq++;
        pool.push_back(r);
      end
    end
  end

  task automatic enq(int tid, int bank, int row, int col);
    enq_tid = 4'(tid); enq_bank = 2'(bank); enq_row = 14'(row); enq_col = 7'(col);
    enq_valid = 1'b1;
    @(posedge clk); #5;
    enq_valid = 1'b0;
  endtask

  task automatic drain();
    iss_ready = 1'b1;
    while (pool.size() != 0) begin @(posedge clk); #5; end
    repeat (ML + 2) begin @(posedge clk); #5; end
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin m_cnt[b] = 0; m_open[b] = 0; m_pend[b] = 0; m_orow[b] = 0; m_prow[b] = 0; end
    repeat (3) @(posedge clk);
    #5;
    check("R5 reset iss_valid", 64'(iss_valid), 64'd0);
    check("R5 reset enq_ready", 64'(enq_ready), 64'd1);
    rst_n = 1'b1;
    @(posedge clk); #5;

    // hit-first and oldest-first in one bank (R1 R2 R4)
    enq(1, 0, 3, 1); enq(2, 0, 7, 2); enq(3, 0, 3, 3); enq(4, 1, 4, 4);
    repeat (3) begin @(posedge clk); #5; end
    check("R8 nothing leaves while ready low", 64'(pool.size()), 64'd4);
    drain();
    check("R1 R2 all issued", 64'(issued), 64'd4);

    // wrong-order arrivals in several banks, hits to previously opened rows
    iss_ready = 1'b0;
    enq(5, 1, 9, 0); enq(6, 0, 7, 1); enq(7, 1, 4, 2); enq(8, 0, 2, 3); enq(9, 1, 4, 5);
    drain();

    // full buffer (R6)
    iss_ready = 1'b0;
    for (int i = 0; i < DEP + 2; i++) enq(i % 16, i % 4, i % 3, i % 128);
    check("R6 full enq_ready", 64'(enq_ready), 64'd0);
    check("R6 full occupancy", 64'(pool.size()), 64'(DEP));
    begin
      int base;
      base = issued;
      drain();
      check("R6 drained count", 64'(issued - base), 64'(DEP));
    end
    check("R6 empty iss_valid", 64'(iss_valid), 64'd0);

    // plain open-row update (R7)
    upd_valid = 1'b1; upd_bank = 2'd3; upd_row = 14'd11;
    @(posedge clk); #5;
    upd_valid = 1'b0;
    enq(10, 3, 11, 7);
    check("R7 update gives hit", 64'(iss_valid && iss_hit), 64'd1);
    drain();

    // conflict completion and update on the same edge (R7)
    iss_ready = 1'b0;
    enq(11, 2, 5, 1); enq(12, 2, 5, 2); enq(13, 2, 9, 3);
    iss_ready = 1'b1;
    @(negedge clk);
    while (!(iss_valid && iss_ready && iss_bank == 2'd2)) @(negedge clk);
    @(posedge clk);
    repeat (ML - 1) @(posedge clk);
    #5;
    upd_valid = 1'b1; upd_bank = 2'd2; upd_row = 14'd9;
    @(posedge clk); #5;
    upd_valid = 1'b0;
    check("R7 update wins collision", pack(iss_tid, iss_bank, iss_row, iss_col, iss_hit),
          pack(13, 2, 9, 3, 1'b1));
    drain();

    // random traffic with stamp wrap (R9) and ready backpressure (R8)
    for (int n = 0; n < 1500; n++) begin
      iss_ready = ($urandom_range(3) != 0);
      upd_valid = ($urandom_range(19) == 0);
      upd_bank = 2'($urandom_range(3));
      upd_row = 14'($urandom_range(3));
      if (pool.size() < 8)
        enq($urandom_range(15), $urandom_range(3), $urandom_range(3), $urandom_range(127));
      else begin @(posedge clk); #5; end
    end
    upd_valid = 1'b0;
    drain();
    check("R9 random drained", 64'(pool.size()), 64'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule